// File: doc/BRIEF.md
# Power-Managed ADC Sampling Host

This block is the host side of a three-wire link to a 12-bit serial sampling converter. It drives the active-low select (`cs_n`) and the serial clock (`sclk`) and shifts in the converter's data line. Each full frame carries four zero bits and then the 12-bit result, MSB first. The host removes the four zero bits and places the result on a valid/ready stream. It also checks those four bits and marks the sample when any of them is set.

Power control uses frame length only. No register is written. A frame cut off after a few clock edges puts the converter to sleep. A full frame, with its data thrown away, starts waking it up. The host records whether the converter is awake. Before any conversion on a sleeping converter it inserts a wake frame and then a power-up wait. It keeps the select line high for a quiet interval between frames.

Commands are single conversion, burst of N conversions followed by power-down, and power-down alone. The command port is a valid/ready handshake and takes one command whenever the host is idle. The sample stream applies back-pressure. A sample stays on the port with its data held until the consumer takes it. While a sample is waiting, no new conversion frame starts. A conversion frame may start in the same cycle that the waiting sample is taken.

Top module: `adc_sample_host`

## Requirements
- R1: After reset `cs_n`=1, `sclk`=1, `smp_valid`=0, `cmd_ready`=1 and `conv_awake`=0. The host assumes the converter is asleep.
- R2: A conversion frame holds `cs_n` low for 16 `sclk` periods, and `sclk` stays high whenever `cs_n` is high. Each period starts with a falling edge. The host samples `sdata` on every rising edge, MSB first. `smp_data` is the last 12 bits shifted in, and `smp_valid` rises the cycle after `cs_n` rises.
- R3: `smp_err` is 1 exactly when any of the first four bits of the frame was 1, and 0 otherwise.
- R4: A conversion command on a sleeping converter first runs a 16-period wake frame and delivers no sample from it. The next frame starts no sooner than `PWRUP_CYC` clocks after the wake frame ends.
- R5: A power-down frame raises `cs_n` after exactly 5 falling edges of `sclk`, and `conv_awake` then reads 0. A power-down command (`cmd_op[1]`=1) on a sleeping converter runs no frame.
- R6: A burst (`cmd_op`=2'b01) delivers `cmd_count` samples and then runs one power-down frame. A count of zero is handled as one.
- R7: A single conversion (`cmd_op`=2'b00) leaves the converter awake (`conv_awake`=1). A following single conversion runs exactly one frame.
- R8: Between any two frames, and between reset and the first frame, `cs_n` stays high for at least `QUIET_CYC` clocks.
- R9: While `smp_valid`=1 and `smp_ready`=0, `smp_data` and `smp_err` hold and no conversion frame starts. When the consumer takes the sample, the next conversion frame may start on that same edge.
- R10: `cmd_ready` falls on the edge that accepts a command and stays low until the whole sequence has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Host idle, command taken on this edge if valid |
| cmd_op | input | 2 | 00 single, 01 burst, 1x power-down |
| cmd_count | input | CNT_W | Burst length (0 treated as 1) |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | input | 1 | Serial data from converter |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts sample |
| smp_data | output | DATA_W | Conversion result without leading zeros |
| smp_err | output | 1 | Leading bits were not all zero |
| conv_awake | output | 1 | Host's view of converter power state |

## Verification
Two events can land on the same clock edge: the consumer taking a waiting sample and the sequencer starting the next conversion frame. The bench provokes this by running a burst with `smp_ready` held low. It waits well past the quiet and power-up intervals while checking that the sample holds and no frame starts. It then raises `smp_ready` for exactly one cycle. The check passes if `cs_n` is already low at the next sampling point and the following sample carries the correct next value.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    FR_WAKE = 2'd0,
    FR_DATA = 2'd1,
    FR_DOWN = 2'd2
  } frame_kind_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PLAN  = 2'd1,
    SQ_FRAME = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_down_timer.sv
module adc_down_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= W'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int HALF_CYC  = 2,
  parameter int MAX_EDGES = 16,
  localparam int EDGE_W   = $clog2(MAX_EDGES + 1),
  localparam int IDX_W    = EDGE_W + 1,
  localparam int DIV_W    = $clog2(HALF_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [EDGE_W-1:0]    edges,
  input  logic                 sdata,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 done,
  output logic [MAX_EDGES-1:0] word
);
  logic              busy;
  logic [DIV_W-1:0]  div_cnt;
  logic [IDX_W-1:0]  half_idx;
  logic [EDGE_W-1:0] edges_q;

  // half 0 is a lead-in with sclk high; odd halves low, even halves high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      done     <= 1'b0;
      div_cnt  <= '0;
      half_idx <= '0;
      edges_q  <= '0;
      word     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          cs_n     <= 1'b0;
          sclk     <= 1'b1;
          div_cnt  <= '0;
          half_idx <= '0;
          edges_q  <= edges;
          word     <= '0;
        end
      end else if (div_cnt == DIV_W'(HALF_CYC - 1)) begin
        div_cnt <= '0;
        if (half_idx == {edges_q, 1'b0}) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
          sclk <= 1'b1;
          done <= 1'b1;
        end else begin
          half_idx <= half_idx + 1'b1;
          sclk     <= half_idx[0];
          if (half_idx[0]) word <= {word[MAX_EDGES-2:0], sdata};
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
      out_err   <= push_err;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sample_host.sv
module adc_sample_host
  import adc_host_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 4,
  parameter int SCLK_HALF = 2,
  parameter int QUIET_CYC = 4,
  parameter int PWRUP_CYC = 100,
  parameter int PD_EDGES  = 5,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdata,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_err,
  output logic              conv_awake
);
  localparam int FRAME_EDGES = DATA_W + LEAD_W;
  localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);
  localparam int QW          = $clog2(QUIET_CYC + 2);
  localparam int PW          = $clog2(PWRUP_CYC + 2);

  seq_state_t        state;
  frame_kind_t       kind_q, want;
  logic [CNT_W-1:0]  remaining;
  logic              pd_pend, awake;
  logic              quiet_done, pwr_done, buf_free, has_work, can_launch;
  logic              frame_done;
  logic [EDGE_W-1:0] launch_edges;
  logic [FRAME_EDGES-1:0] word;

  assign buf_free = !smp_valid || smp_ready;
  assign has_work = (remaining != '0) || (pd_pend && awake);

  always_comb begin
    if (remaining != '0) want = awake ? FR_DATA : FR_WAKE;
    else                 want = FR_DOWN;
  end

  assign can_launch   = (state == SQ_PLAN) && has_work && quiet_done &&
                        ((want != FR_DATA) || (pwr_done && buf_free));
  assign launch_edges = (want == FR_DOWN) ? EDGE_W'(PD_EDGES) : EDGE_W'(FRAME_EDGES);
  assign cmd_ready    = (state == SQ_IDLE);
  assign conv_awake   = awake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      kind_q    <= FR_WAKE;
      remaining <= '0;
      pd_pend   <= 1'b0;
      awake     <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (cmd_valid) begin
          state <= SQ_PLAN;
          if (cmd_op[1]) begin
            remaining <= '0;
            pd_pend   <= 1'b1;
          end else begin
            pd_pend <= cmd_op[0];
            if (cmd_op[0] && cmd_count != '0) remaining <= cmd_count;
            else                              remaining <= CNT_W'(1);
          end
        end
        SQ_PLAN: begin
          if (!has_work) begin
            state   <= SQ_IDLE;
            pd_pend <= 1'b0;
          end else if (can_launch) begin
            kind_q <= want;
            state  <= SQ_FRAME;
          end
        end
        SQ_FRAME: if (frame_done) begin
          state <= SQ_PLAN;
          case (kind_q)
            FR_WAKE: awake <= 1'b1;
            FR_DATA: remaining <= remaining - 1'b1;
            FR_DOWN: begin
              awake   <= 1'b0;
              pd_pend <= 1'b0;
            end
            default: ;
          endcase
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  adc_frame_engine #(.HALF_CYC(SCLK_HALF), .MAX_EDGES(FRAME_EDGES)) u_engine (
    .clk   (clk),
    .rst_n (rst_n),
    .start (can_launch),
    .edges (launch_edges),
    .sdata (sdata),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .done  (frame_done),
    .word  (word)
  );

  adc_down_timer #(.W(QW), .RST_VAL(QUIET_CYC)) u_quiet (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_done),
    .load_val (QW'(QUIET_CYC)),
    .expired  (quiet_done)
  );

  adc_down_timer #(.W(PW), .RST_VAL(0)) u_pwrup (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_done && kind_q == FR_WAKE),
    .load_val (PW'(PWRUP_CYC)),
    .expired  (pwr_done)
  );

  adc_sample_buffer #(.DW(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frame_done && kind_q == FR_DATA),
    .push_data (word[DATA_W-1:0]),
    .push_err  (|word[FRAME_EDGES-1:DATA_W]),
    .out_valid (smp_valid),
    .out_ready (smp_ready),
    .out_data  (smp_data),
    .out_err   (smp_err)
  );
endmodule

// File: rtl/adc_sample_host_chk.sv
module adc_sample_host_chk #(
  parameter int DATA_W      = 12,
  parameter int QUIET_CYC   = 4,
  parameter int FRAME_EDGES = 16,
  parameter int PD_EDGES    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_err,
  input logic              cmd_ready
);
  logic       cs_d, sclk_d;
  logic [5:0] fall_cnt;
  int         high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d     <= 1'b1;
      sclk_d   <= 1'b1;
      fall_cnt <= '0;
      high_cnt <= 0;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
      if (cs_d && !cs_n)                 fall_cnt <= '0;
      else if (!cs_n && sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n)                         high_cnt <= 0;
      else if (high_cnt < QUIET_CYC + 1) high_cnt <= high_cnt + 1;
    end
  end

  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r2_sample_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> ($past(cs_n) && !$past(cs_n, 2)));

  a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fall_cnt == 6'(FRAME_EDGES) || fall_cnt == 6'(PD_EDGES)));

  a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt >= QUIET_CYC));

  a_r9_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_err)));

  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cs_n);
endmodule

bind adc_sample_host adc_sample_host_chk #(
  .DATA_W(DATA_W), .QUIET_CYC(QUIET_CYC), .FRAME_EDGES(FRAME_EDGES), .PD_EDGES(PD_EDGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .smp_data(smp_data), .smp_err(smp_err), .cmd_ready(cmd_ready)
);

// File: tb/adc_sample_host_test.sv
module adc_sample_host_test;
  localparam int QUIET = 4;
  localparam int PWRUP = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_count = 8'd0;
  logic       sdata = 1'b0;
  logic       smp_ready = 1'b0;
  logic       cmd_ready, cs_n, sclk, smp_valid, smp_err, conv_awake;
  logic [11:0] smp_data;

  adc_sample_host #(.QUIET_CYC(QUIET), .PWRUP_CYC(PWRUP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_count(cmd_count), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .smp_err(smp_err), .conv_awake(conv_awake)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;
  int cyc = 0;

  // converter model state
  int  f16 = 0, f5 = 0, badlen = 0, quiet_viol = 0, early_viol = 0;
  int  fall_k = 0, last_rise = 0, wake_cyc = 0;
  bit  m_awake = 1'b0, frame_good = 1'b0, inject = 1'b0, cur_inj = 1'b0;
  logic [11:0] val = 12'h5A1;
  logic [15:0] cur_word = '0;
  int  exp_data [0:63];
  bit  exp_err [0:63];
  int  wr_idx = 0, rd_idx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // converter responder, evaluated between clock edges
  initial begin
    logic cs_p, sc_p;
    cs_p = 1'b1;
    sc_p = 1'b1;
    forever begin
      @(negedge clk);
      if (cs_p && !cs_n) begin
        if (cyc - last_rise < QUIET) quiet_viol++;
        fall_k = 0;
        frame_good = m_awake && (cyc - wake_cyc >= PWRUP);
        cur_inj = inject;
        cur_word = {(inject ? 4'h2 : 4'h0), val};
        sdata = cur_word[15];
      end else if (!cs_n && sc_p && !sclk) begin
        fall_k++;
        if (fall_k <= 16) sdata = cur_word[16 - fall_k];
      end else if (!cs_p && cs_n) begin
        last_rise = cyc;
        if (fall_k == 16) f16++;
        else if (fall_k == 5) f5++;
        else badlen++;
        if (!m_awake) begin
          if (fall_k >= 10) begin
            m_awake = 1'b1;
            wake_cyc = cyc;
          end
        end else if (fall_k >= 2 && fall_k < 10) begin
          m_awake = 1'b0;
        end else if (fall_k == 16) begin
          if (frame_good) begin
            exp_data[wr_idx] = int'(val);
            exp_err[wr_idx] = cur_inj;
            wr_idx++;
            if (cur_inj) inject = 1'b0;
            val = val + 12'h3C7;
          end else early_viol++;
        end
      end
      cs_p = cs_n;
      sc_p = sclk;
    end
  end

  // sample consumer check, just after the negedge where ready is driven
  initial forever begin
    @(negedge clk);
    #1;
    if (smp_valid && smp_ready) begin
      if (rd_idx >= wr_idx) chk(1'b0, "R2 unexpected sample", int'(smp_data), -1);
      else begin
        chk(int'(smp_data) == exp_data[rd_idx], "R2 sample data", int'(smp_data), exp_data[rd_idx]);
        chk(smp_err == exp_err[rd_idx], "R3 framing flag", int'(smp_err), int'(exp_err[rd_idx]));
      end
      rd_idx++;
    end
  end

  initial begin
    #2000000;
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  task automatic send(input logic [1:0] op, input logic [7:0] cnt);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_count = cnt;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10 busy after accept", int'(cmd_ready), 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cmd_ready && !smp_valid)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    chk(quiet_viol == 0, "R8 quiet gap", quiet_viol, 0);
    chk(early_viol == 0, "R4 power-up wait", early_viol, 0);
    chk(badlen == 0, tag, badlen, 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sclk == 1, "R1 select and clock idle", int'({cs_n, sclk}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_valid == 0, "R1 no sample", int'(smp_valid), 0);
    chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
    chk(conv_awake == 0, "R1 asleep", int'(conv_awake), 0);
  endtask

  task automatic t_single_cold();
    int f0 = f16, r0 = rd_idx;
    smp_ready = 1'b1;
    send(2'b00, 8'd0);
    wait_idle();
    chk(f16 - f0 == 2, "R4 wake plus data frame", f16 - f0, 2);
    chk(rd_idx - r0 == 1, "R4 wake data discarded", rd_idx - r0, 1);
    chk(conv_awake == 1, "R7 awake after single", int'(conv_awake), 1);
    check_model("R2 frame length");
  endtask

  task automatic t_single_warm();
    int f0 = f16, r0 = rd_idx;
    send(2'b00, 8'd0);
    wait_idle();
    chk(f16 - f0 == 1, "R7 no wake frame", f16 - f0, 1);
    chk(rd_idx - r0 == 1, "R7 one sample", rd_idx - r0, 1);
  endtask

  task automatic t_error_flag();
    int r0 = rd_idx;
    inject = 1'b1;
    send(2'b00, 8'd0);
    wait_idle();
    chk(rd_idx - r0 == 1 && !inject, "R3 flagged sample taken", rd_idx - r0, 1);
  endtask

  task automatic t_powerdown();
    int p0 = f5, g0 = f16;
    send(2'b10, 8'd0);
    wait_idle();
    chk(f5 - p0 == 1, "R5 one short frame", f5 - p0, 1);
    chk(conv_awake == 0 && !m_awake, "R5 asleep", int'(conv_awake), 0);
    send(2'b11, 8'd0);
    wait_idle();
    chk(f5 - p0 == 1 && f16 == g0, "R5 no frame when asleep", f5 - p0, 1);
  endtask

  task automatic t_burst();
    int f0 = f16, p0 = f5, r0 = rd_idx;
    send(2'b01, 8'd3);
    wait_idle();
    chk(rd_idx - r0 == 3, "R6 burst samples", rd_idx - r0, 3);
    chk(f16 - f0 == 4, "R6 wake plus three", f16 - f0, 4);
    chk(f5 - p0 == 1 && conv_awake == 0, "R6 trailing power-down", f5 - p0, 1);
    r0 = rd_idx;
    send(2'b01, 8'd0);
    wait_idle();
    chk(rd_idx - r0 == 1, "R6 zero count as one", rd_idx - r0, 1);
    check_model("R5 frame length");
  endtask

  task automatic t_backpressure();
    int r0 = rd_idx, g0;
    logic [11:0] held;
    smp_ready = 1'b0;
    send(2'b01, 8'd2);
    while (!smp_valid) @(negedge clk);
    held = smp_data;
    g0 = f16;
    repeat (200) @(negedge clk);
    chk(f16 == g0 && cs_n == 1, "R9 no frame while stalled", f16 - g0, 0);
    chk(smp_valid == 1 && smp_data == held, "R9 sample held", int'(smp_data), int'(held));
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
    chk(cs_n == 0, "R9 launch on accept edge", int'(cs_n), 0);
    while (!smp_valid) @(negedge clk);
    smp_ready = 1'b1;
    wait_idle();
    chk(rd_idx - r0 == 2, "R9 samples after stall", rd_idx - r0, 2);
    check_model("R9 frame length");
  endtask

  initial begin
    t_reset();
    t_single_cold();
    t_single_warm();
    t_error_flag();
    t_powerdown();
    t_burst();
    t_backpressure();
    chk(rd_idx == wr_idx, "R2 all samples delivered", rd_idx, wr_idx);
    finish_run();
  end
endmodule